// File: doc/BRIEF.md
# One-Hot Select Word Rotator

This block turns a narrow data word to the left by an amount chosen on a set of one-hot steering lines. Each steering line enables one fixed wiring pattern of the input bits onto the output. Raising line k moves every input bit k places toward the more significant end. Bits that pass the top of the word come back in at bit 0.

The block is purely combinational. It holds no state and has no clock or reset. The output settles from the present inputs alone.

If the steering vector has no line raised, the output is forced to zero and the flag stays low. If more than one line is raised, the output is also forced to zero and the flag goes high. The word width `WIDTH` is a parameter, and the number of steering lines equals the width. The default is 4.

Top module: `rotl_onehot_array`

## Requirements
- R1: With only steering line 0 raised (sel = 4'b0001), the output equals the input bit for bit.
- R2: With only steering line 1 raised (sel = 4'b0010), the output bits 3..0 are {d[2], d[1], d[0], d[3]}.
- R3: With only steering line 2 raised (sel = 4'b0100), the output bits 3..0 are {d[1], d[0], d[3], d[2]}.
- R4: With only steering line 3 raised (sel = 4'b1000), the output bits 3..0 are {d[0], d[3], d[2], d[1]}.
- R5: With no steering line raised (sel = 4'b0000), the output is all zeros and the fault flag is 0.
- R6: With two or more steering lines raised, the output is all zeros and the fault flag is 1.
- R7: The block holds no state. Outputs follow any change of the inputs within the same clock period, with no edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel | input | WIDTH | One-hot steering lines; line k selects a left turn by k places |
| d | input | WIDTH | Data word to be turned |
| q | output | WIDTH | Turned word, or zero when the steering is not one-hot |
| fault | output | 1 | High when more than one steering line is raised |

## Verification
Every result is due in zero cycles, because no register lies between any input and any output. The bench applies each stimulus one nanosecond after a rising edge. It compares against its own behavioural model at the following falling edge, so each check falls inside the same period as its stimulus. Every data word is swept against all sixteen steering vectors. The sweep covers the four legal vectors, the all-zero vector and the eleven vectors with more than one line raised. The settled output is also checked after a data change with the steering held fixed.

// File: rtl/rotl_onehot_array.sv
module rotl_onehot_array #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] sel,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             fault
);

  localparam int DBL = 2 * WIDTH;

  logic [WIDTH-1:0] lane [WIDTH];
  logic [WIDTH-1:0] merged;
  logic             single;
  logic             any;

  genvar k;
  generate
    for (k = 0; k < WIDTH; k++) begin : g_lane
      logic [DBL-1:0] twice;
      assign twice   = {d, d} >> (WIDTH - k);
      assign lane[k] = twice[WIDTH-1:0] & {WIDTH{sel[k]}};
    end
  endgenerate

  always_comb begin
    merged = '0;
    for (int i = 0; i < WIDTH; i++) merged = merged | lane[i];
  end

  assign any    = |sel;
  assign single = any && ((sel & (sel - 1'b1)) == '0);
  assign q      = single ? merged : '0;
  assign fault  = any && !single;

endmodule

// File: rtl/rotl_onehot_array_chk.sv
module rotl_onehot_array_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] sel,
  input logic [WIDTH-1:0] d,
  input logic [WIDTH-1:0] q,
  input logic             fault
);

  always_comb begin
    // R1
    if (sel == 1) identity_chk: assert (q == d);
    // R2, R3, R4
    for (int k = 1; k < WIDTH; k++)
      if (sel == (1 << k))
        for (int b = 0; b < WIDTH; b++)
          turn_chk: assert (q[(b + k) % WIDTH] == d[b]);
    // R5
    if (sel == '0) idle_zero_chk: assert (q == '0 && !fault);
    // R6
    if ($countones(sel) > 1) multi_zero_chk: assert (q == '0 && fault);
    // R6
    fault_only_multi_chk: assert (fault == ($countones(sel) > 1));
  end

endmodule

bind rotl_onehot_array rotl_onehot_array_chk #(.WIDTH(WIDTH)) u_chk (
  .sel(sel), .d(d), .q(q), .fault(fault)
);

// File: tb/tb_rotl_onehot_array.sv
module tb_rotl_onehot_array;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic [W-1:0] sel = '0;
  logic [W-1:0] d   = '0;
  logic [W-1:0] q;
  logic         fault;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rotl_onehot_array #(.WIDTH(W)) dut (.sel(sel), .d(d), .q(q), .fault(fault));

  function automatic string req_of(input logic [W-1:0] s);
    case (s)
      4'b0001: return "R1";
      4'b0010: return "R2";
      4'b0100: return "R3";
      4'b1000: return "R4";
      4'b0000: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic apply_and_check(input logic [W-1:0] s, input logic [W-1:0] w, input string tag);
    int ones;
    int amt;
    logic [W-1:0] exp_q;
    logic exp_f;
    @(posedge clk);
    #1;
    sel = s;
    d = w;
    @(negedge clk);
    ones = 0;
    amt = 0;
    for (int i = 0; i < W; i++) if (s[i]) begin ones++; amt = i; end
    exp_q = '0;
    if (ones == 1)
      for (int i = 0; i < W; i++) exp_q[(i + amt) % W] = w[i];
    exp_f = (ones > 1);
    checks++;
    if (q !== exp_q || fault !== exp_f) begin
      failures++;
      $display("FAIL %s sel=%b d=%b actual q=%b fault=%b expected q=%b fault=%b",
               tag, s, w, q, fault, exp_q, exp_f);
    end
  endtask

  initial begin
    // R5: quiescent state with all inputs low
    apply_and_check(4'b0000, 4'b0000, "R5");
    // R1 R2 R3 R4 R5 R6: full sweep
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 16; w++)
        apply_and_check(4'(s), 4'(w), req_of(4'(s)));
    // R7: data changes with steering held, result due in the same period
    apply_and_check(4'b0010, 4'b1001, "R7");
    apply_and_check(4'b0010, 4'b0110, "R7");
    apply_and_check(4'b1000, 4'b0001, "R7");
    apply_and_check(4'b1000, 4'b1110, "R7");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule